// File: doc/BRIEF.md
# Multiplexed 1/3-Duty LCD Waveform Sequencer

This block turns a 96-cell display image into the time-multiplexed drive pattern for a passive LCD panel. The panel has three common lines and thirty-two segment lines. For every line, the block outputs a 2-bit level code, and an analog output stage uses that code to pick one of four drive rails. The block only sequences: it decides which common is being scanned and which polarity half the frame is in. Rail generation and the oscillator are outside the block.

The block advances on a one-clock-wide oscillator tick. Each common gets a scan slot of 64 ticks. The three slots run once with positive polarity and once with negative polarity, so a full frame lasts 384 ticks and the panel sees no DC component.

Three plain control flags change the output. One selects half bias instead of third bias. One blanks the image while scanning goes on. One enters low power: scanning is frozen and every line is pulled to ground. The display image is a static level input sampled combinationally, so there is no streaming interface and no back-pressure.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: Level codes are 0 = ground, 1 = lower intermediate rail, 2 = upper intermediate rail, 3 = supply. Common k drives `com_lvl[2k+1:2k]` and segment s drives `seg_lvl[2s+1:2s]`. The cell of segment s on common c is `image[3*s+c]`.
- R2: After reset, and in the first cycle after low power is left, the scan is in the slot of common 0 with positive polarity.
- R3: Every slot lasts 64 accepted ticks. Slots visit common 0, 1 and 2 in that order. After common 2, polarity flips, so the pattern repeats every 384 ticks.
- R4: With third bias, the scanned common is at code 3 in the positive half and code 0 in the negative half. The other two commons are at code 1 in the positive half and code 2 in the negative half.
- R5: A lit segment is at the extreme opposite the scanned common: code 0 in the positive half and code 3 in the negative half. With third bias, an unlit segment is at code 2 in the positive half and code 1 in the negative half. Image changes show up at the segment outputs in the same cycle.
- R6: With half bias, unscanned commons and unlit segments are at code 1 in both halves, and code 2 never appears on any output.
- R7: With blanking set, every segment shows its unlit level whatever the image, and the scan keeps advancing on ticks.
- R8: With low power set, all common and segment codes are 0 and ticks are ignored.
- R9: The scan position changes only on a clock edge where the tick is high. If no tick arrives, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator pulse that advances the scan |
| image | input | 96 | Display image; bit 3*s+c is segment s on common c |
| bias_half | input | 1 | 1 selects half bias, 0 selects third bias |
| blank | input | 1 | 1 shows every cell as unlit |
| low_power | input | 1 | 1 freezes scanning and grounds all outputs |
| com_lvl | output | 6 | Two-bit level code per common |
| seg_lvl | output | 64 | Two-bit level code per segment |

## Verification
The hardest states to reach are the last tick of a slot and the polarity flip, which only arrive after exact runs of 64 or 192 accepted ticks. The bench uses a short low-power pulse to return the scan to a known origin, then issues exact tick counts so it can sample at ticks 63, 64, 192 and 383, and at the wrap back to the origin. Randomly gapped tick runs under random images and bias settings then cover arbitrary slot and polarity positions. A reference tick count kept in the bench predicts every output code.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_SUP  = 2'd3
  } lvl_e;

  // Level for a common line: scanned lines swing to an extreme,
  // idle lines sit on the rail nearest the opposite extreme.
  function automatic lvl_e common_level(logic scanned, logic neg, logic half);
    lvl_e r;
    if (scanned)   r = neg ? LVL_GND : LVL_SUP;
    else if (half) r = LVL_LOW;
    else           r = neg ? LVL_HIGH : LVL_LOW;
    return r;
  endfunction

  // Level for a segment line relative to the scanned common.
  function automatic lvl_e segment_level(logic lit, logic neg, logic half);
    lvl_e r;
    if (lit)       r = neg ? LVL_SUP : LVL_GND;
    else if (half) r = LVL_LOW;
    else           r = neg ? LVL_LOW : LVL_HIGH;
    return r;
  endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer #(
  parameter int NUM_COM    = 3,
  parameter int SLOT_TICKS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_tick,
  input  logic               hold_clear,
  output logic [NUM_COM-1:0] slot_oh,
  output logic               neg_half
);
  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_COM - 1);

  logic [TICK_W-1:0] tick_q;
  logic [SLOT_W-1:0] slot_q;
  logic              neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else if (hold_clear) begin
      tick_q <= '0;
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else if (osc_tick) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        if (slot_q == SLOT_LAST) begin
          slot_q <= '0;
          neg_q  <= ~neg_q;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_COM; k++) begin : g_oh
    assign slot_oh[k] = (slot_q == SLOT_W'(k));
  end

  assign neg_half = neg_q;
endmodule

// File: rtl/lcd_com_driver.sv
`timescale 1ns/1ps
module lcd_com_driver
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 3
) (
  input  logic                 quiet,
  input  logic                 bias_half,
  input  logic                 neg_half,
  input  logic [NUM_COM-1:0]   slot_oh,
  output logic [2*NUM_COM-1:0] com_lvl
);
  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    lvl_e lvl;
    always_comb begin
      if (quiet) lvl = LVL_GND;
      else       lvl = common_level(slot_oh[k], neg_half, bias_half);
    end
    assign com_lvl[2*k +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_seg_driver.sv
`timescale 1ns/1ps
module lcd_seg_driver
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 3,
  parameter int NUM_SEG = 32
) (
  input  logic                       quiet,
  input  logic                       blank,
  input  logic                       bias_half,
  input  logic                       neg_half,
  input  logic [NUM_COM-1:0]         slot_oh,
  input  logic [NUM_COM*NUM_SEG-1:0] image,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] column;
    logic               lit;
    lvl_e               lvl;
    assign column = image[s*NUM_COM +: NUM_COM];
    assign lit    = (|(column & slot_oh)) & ~blank;
    always_comb begin
      if (quiet) lvl = LVL_GND;
      else       lvl = segment_level(lit, neg_half, bias_half);
    end
    assign seg_lvl[2*s +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
`timescale 1ns/1ps
module lcd_mux_sequencer #(
  parameter int NUM_COM    = 3,
  parameter int NUM_SEG    = 32,
  parameter int SLOT_TICKS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_tick,
  input  logic [NUM_COM*NUM_SEG-1:0] image,
  input  logic                       bias_half,
  input  logic                       blank,
  input  logic                       low_power,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  logic [NUM_COM-1:0] slot_oh;
  logic               neg_half;

  lcd_scan_timer #(.NUM_COM(NUM_COM), .SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .hold_clear(low_power),
    .slot_oh   (slot_oh),
    .neg_half  (neg_half)
  );

  lcd_com_driver #(.NUM_COM(NUM_COM)) u_com (
    .quiet    (low_power),
    .bias_half(bias_half),
    .neg_half (neg_half),
    .slot_oh  (slot_oh),
    .com_lvl  (com_lvl)
  );

  lcd_seg_driver #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seg (
    .quiet    (low_power),
    .blank    (blank),
    .bias_half(bias_half),
    .neg_half (neg_half),
    .slot_oh  (slot_oh),
    .image    (image),
    .seg_lvl  (seg_lvl)
  );
endmodule

// File: rtl/lcd_seq_checker.sv
`timescale 1ns/1ps
module lcd_seq_checker #(
  parameter int NUM_COM = 3,
  parameter int NUM_SEG = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_tick,
  input logic                 bias_half,
  input logic                 blank,
  input logic                 low_power,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl
);
  logic [NUM_COM-1:0] com_ext;
  logic               any_high;
  logic               seg_ext;

  always_comb begin
    com_ext  = '0;
    any_high = 1'b0;
    seg_ext  = 1'b0;
    for (int k = 0; k < NUM_COM; k++) begin
      com_ext[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
      if (com_lvl[2*k +: 2] == 2'd2) any_high = 1'b1;
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      if (seg_lvl[2*s +: 2] == 2'd2) any_high = 1'b1;
      if ((seg_lvl[2*s +: 2] == 2'd0) || (seg_lvl[2*s +: 2] == 2'd3)) seg_ext = 1'b1;
    end
  end

  // R8
  lp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (com_lvl == '0 && seg_lvl == '0));

  // R4
  one_scanned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |-> ($countones(com_ext) == 1));

  // R6
  half_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_power && bias_half) |-> !any_high);

  // R7
  blank_unlit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_power && blank) |-> !seg_ext);

  // R2
  restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(low_power) && !low_power) |-> (com_lvl[1:0] == 2'd3));

  // R9
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !low_power) |=>
      (low_power || (bias_half != $past(bias_half)) || (com_lvl == $past(com_lvl))));
endmodule

bind lcd_mux_sequencer lcd_seq_checker #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_tick (osc_tick),
  .bias_half(bias_half),
  .blank    (blank),
  .low_power(low_power),
  .com_lvl  (com_lvl),
  .seg_lvl  (seg_lvl)
);

// File: tb/test_lcd_mux_sequencer.sv
`timescale 1ns/1ps
module test_lcd_mux_sequencer;
  localparam int NC = 3;
  localparam int NS = 32;
  localparam int ST = 64;
  localparam int HALF = NC * ST;
  localparam int FR = 2 * HALF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              osc_tick = 1'b0;
  logic              bias_half = 1'b0;
  logic              blank = 1'b0;
  logic              low_power = 1'b0;
  logic [NC*NS-1:0]  image = '0;
  logic [2*NC-1:0]   com_lvl;
  logic [2*NS-1:0]   seg_lvl;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;

  lcd_mux_sequencer i_lcd_mux_sequencer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .image(image),
    .bias_half(bias_half), .blank(blank), .low_power(low_power),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // Reference levels from the requirements (R1, R4, R5, R6, R7, R8)
  function automatic logic [1:0] ref_com(int k);
    int slot = (n % HALF) / ST;
    bit neg  = (n >= HALF);
    if (low_power) return 2'd0;
    if (k == slot) return neg ? 2'd0 : 2'd3;
    if (bias_half) return 2'd1;
    return neg ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] ref_seg(int s);
    int slot = (n % HALF) / ST;
    bit neg  = (n >= HALF);
    bit lit  = image[s*NC + slot] && !blank;
    if (low_power) return 2'd0;
    if (lit) return neg ? 2'd3 : 2'd0;
    if (bias_half) return 2'd1;
    return neg ? 2'd1 : 2'd2;
  endfunction

  task automatic check(string tc, string ts);
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    for (int k = 0; k < NC; k++) ec[2*k +: 2] = ref_com(k);
    for (int s = 0; s < NS; s++) es[2*s +: 2] = ref_seg(s);
    checks += 2;
    if (com_lvl !== ec) begin
      fails++;
      $display("FAIL %s com_lvl actual=%h expected=%h (pos %0d)", tc, com_lvl, ec, n);
    end
    if (seg_lvl !== es) begin
      fails++;
      $display("FAIL %s seg_lvl actual=%h expected=%h (pos %0d)", ts, seg_lvl, es, n);
    end
  endtask

  task automatic cyc(bit t);
    @(negedge clk);
    osc_tick = t;
    @(posedge clk);
    if (!rst_n || low_power) n = 0;
    else if (t) n = (n + 1) % FR;
    #1;
  endtask

  task automatic look();
    @(negedge clk);
    osc_tick = 1'b0;
    #1;
  endtask

  task automatic ticks(int k);
    repeat (k) cyc(1'b1);
  endtask

  task automatic restart();
    low_power = 1'b1;
    cyc(1'b1);
    cyc(1'b1);
    look();
    check("R8", "R8");          // grounded, ticks ignored
    low_power = 1'b0;
    look();
    check("R2", "R2");          // origin after leaving low power
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    image = {$urandom, $urandom, $urandom};
    cyc(1'b1);
    cyc(1'b0);
    rst_n = 1'b1;
    look();
    check("R2", "R1");          // reset origin, mapping

    // R3 slot boundaries and polarity flip
    restart();
    ticks(63);  look(); check("R3", "R3");
    ticks(1);   look(); check("R3", "R3");
    ticks(128); look(); check("R4", "R5");   // negative half begins
    ticks(191); look(); check("R3", "R3");   // last tick of frame
    ticks(1);   look(); check("R3", "R3");   // wrap to origin

    // R9 no tick, no movement
    ticks(70);
    repeat (25) cyc(1'b0);
    look(); check("R9", "R9");

    // R5 image change seen in same cycle
    image = ~image;
    look(); check("R5", "R5");

    // R7 blanking with all cells lit
    image = '1;
    blank = 1'b1;
    look(); check("R7", "R7");
    ticks(150); look(); check("R7", "R7");
    blank = 1'b0;
    look(); check("R5", "R5");

    // R6 half bias in both halves
    bias_half = 1'b1;
    image = {$urandom, $urandom, $urandom};
    restart();
    ticks(100); look(); check("R6", "R6");
    ticks(100); look(); check("R6", "R6");
    bias_half = 1'b0;

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int k;
      image = {$urandom, $urandom, $urandom};
      bias_half = $urandom % 2;
      k = $urandom % 300;
      repeat (k) cyc(1'($urandom % 2));
      look();
      if (bias_half) check("R6", "R6");
      else           check("R4", "R5");
    end

    // R8 again mid-frame
    ticks(77);
    restart();
    report();
  end
endmodule